// File: doc/BRIEF.md
# Frame Sync Output Generator

This block produces the frame synchronization signal for one direction of a synchronous serial port. All state advances only on cycles where the bit clock enable is high. A trigger comes from one of two sources. One source is an internal period timer. The other is an external transfer start request, used when the period field is zero. Each trigger starts a frame. The block shapes the sync pin in one of five ways: a low pulse, a high pulse, a low level, a high level, or a toggle. For the pulse shapes, the pulse length comes from two 4-bit halves that join into one 8-bit count. For the level shapes, the level is held until the last word of the frame completes.

The block also emits a one-cycle frame start strobe for the data shifter. When the output mode is "input", the pin is released and the strobe follows the selected edge of the incoming sync signal instead. Dropping the enable clears the timers, the counters and the toggle state, so the next enable starts a fresh frame at its first bit tick.

Top module: `fsync_gen`

## Requirements
- R1: With mode code 0, 6 or 7, fs_oe is low and fs_out is low.
- R2: Mode 1 idles high and drives low for L+1 bit ticks from a trigger. Mode 2 idles low and drives high for L+1 bit ticks. L is {len_hi, len_lo}, with len_hi as the upper four bits.
- R3: With period P nonzero, a trigger occurs on the first bit tick after enable and then every 2*(P+1) bit ticks. fs_oe is high in modes 1 to 5 while enabled.
- R4: With P equal to zero, a trigger occurs on each bit tick where start_evt is high. With P nonzero, start_evt has no effect.
- R5: Mode 3 drives low and mode 4 drives high from a trigger until the (words+1)-th word_done bit tick. Otherwise mode 3 rests high and mode 4 rests low.
- R6: Mode 5 inverts fs_out at every trigger. The toggle state returns low whenever en is low.
- R7: frame_start is high for exactly the cycle after each trigger edge. In mode 0 it instead follows fs_in edges seen on bit ticks: rising when edge_sel is 0, falling when edge_sel is 1.
- R8: While bit_en is low, no counter, level or toggle state changes.
- R9: If a trigger falls on the same bit tick as the final word_done, or as a pulse expiry, the trigger wins. The shape stays active and restarts its count.
- R10: With en low, fs_oe is low and frame_start stays low from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable; low clears all frame state |
| bit_en | input | 1 | Bit clock enable; one bit tick per high cycle |
| start_evt | input | 1 | Transfer start request, used when period is 0 |
| word_done | input | 1 | Word completion event, counted on bit ticks |
| fs_in | input | 1 | Incoming sync level used in input mode |
| mode | input | 3 | Output shape code 0..5 |
| len_lo | input | 4 | Pulse length, lower four bits |
| len_hi | input | 4 | Pulse length, upper four bits |
| period | input | 8 | Half frame period minus one; 0 disables the timer |
| words | input | 4 | Words per frame minus one |
| edge_sel | input | 1 | Input mode edge: 0 rising, 1 falling |
| fs_out | output | 1 | Sync pin value |
| fs_oe | output | 1 | Sync pin output enable |
| frame_start | output | 1 | One-cycle frame start strobe |

## Verification
Two functions can land on the same bit tick: a new trigger, and the end of the current shape (pulse expiry or final word_done). The periodic sweeps provoke the pulse case by choosing lengths at and beyond the frame period, where the output must then stay active without a gap. A directed run raises start_evt in the very cycle of the closing word_done in level mode. There the output is judged to remain at its active level and to emit a fresh frame_start, and only a later lone word_done may release it.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [2:0] {
    FS_INPUT    = 3'd0,
    FS_PULSE_LO = 3'd1,
    FS_PULSE_HI = 3'd2,
    FS_LEVEL_LO = 3'd3,
    FS_LEVEL_HI = 3'd4,
    FS_TOGGLE   = 3'd5
  } fs_mode_e;

  function automatic logic is_out_mode(input logic [2:0] m);
    return (m >= 3'd1) && (m <= 3'd5);
  endfunction
endpackage

// File: rtl/fsg_period.sv
module fsg_period #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             bit_en,
  input  logic             start_evt,
  input  logic [PER_W-1:0] period,
  output logic             trig
);
  localparam int CW = PER_W + 1;

  logic [CW-1:0] cnt;
  logic          periodic;

  assign periodic = |period;
  assign trig = en && bit_en && (periodic ? (cnt == '0) : start_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en) begin
      cnt <= '0;
    end else if (bit_en && periodic) begin
      cnt <= (cnt == '0) ? {period, 1'b1} : cnt - 1'b1;
    end
  end
endmodule

// File: rtl/fsg_span.sv
module fsg_span #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic         tick,
  input  logic [W-1:0] val,
  output logic         active
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (clr) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      cnt    <= val;
      active <= 1'b1;
    end else if (tick && active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/fsg_shape.sv
module fsg_shape
  import fsg_pkg::*;
(
  input  logic       en,
  input  logic [2:0] mode,
  input  logic       pulse_act,
  input  logic       level_act,
  input  logic       tgl,
  output logic       fs_out,
  output logic       fs_oe
);
  fs_mode_e m;

  always_comb begin
    m = fs_mode_e'(mode);
    case (m)
      FS_PULSE_LO: fs_out = ~pulse_act;
      FS_PULSE_HI: fs_out =  pulse_act;
      FS_LEVEL_LO: fs_out = ~level_act;
      FS_LEVEL_HI: fs_out =  level_act;
      FS_TOGGLE:   fs_out =  tgl;
      default:     fs_out = 1'b0;
    endcase
    fs_oe = en && is_out_mode(mode);
  end
endmodule

// File: rtl/fsync_gen.sv
module fsync_gen
  import fsg_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int PER_W = 8,
  parameter int WRD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             bit_en,
  input  logic             start_evt,
  input  logic             word_done,
  input  logic             fs_in,
  input  logic [2:0]       mode,
  input  logic [LEN_W-1:0] len_lo,
  input  logic [LEN_W-1:0] len_hi,
  input  logic [PER_W-1:0] period,
  input  logic [WRD_W-1:0] words,
  input  logic             edge_sel,
  output logic             fs_out,
  output logic             fs_oe,
  output logic             frame_start
);
  localparam int PLEN_W = 2 * LEN_W;

  logic              trig;
  logic              pulse_act;
  logic              level_act;
  logic              tgl;
  logic              fs_prev;
  logic              in_edge;
  logic [PLEN_W-1:0] plen;

  assign plen    = {len_hi, len_lo};
  assign in_edge = bit_en && (edge_sel ? (fs_prev && !fs_in) : (!fs_prev && fs_in));

  fsg_period #(.PER_W(PER_W)) u_period (
    .clk(clk), .rst_n(rst_n), .en(en), .bit_en(bit_en),
    .start_evt(start_evt), .period(period), .trig(trig)
  );

  fsg_span #(.W(PLEN_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .clr(!en), .load(trig),
    .tick(bit_en), .val(plen), .active(pulse_act)
  );

  fsg_span #(.W(WRD_W)) u_words (
    .clk(clk), .rst_n(rst_n), .clr(!en), .load(trig),
    .tick(bit_en && word_done), .val(words), .active(level_act)
  );

  fsg_shape u_shape (
    .en(en), .mode(mode), .pulse_act(pulse_act), .level_act(level_act),
    .tgl(tgl), .fs_out(fs_out), .fs_oe(fs_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl         <= 1'b0;
      fs_prev     <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      if (bit_en) fs_prev <= fs_in;
      if (!en)       tgl <= 1'b0;
      else if (trig) tgl <= ~tgl;
      frame_start <= en && (is_out_mode(mode) ? trig : in_edge);
    end
  end
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       bit_en,
  input logic [2:0] mode,
  input logic       fs_out,
  input logic       frame_start
);
  p_strobe_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> $past(bit_en));

  p_no_strobe_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> !frame_start);

  p_neg_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && mode == 3'd1 && $past(mode) == 3'd1) |-> !fs_out);

  p_level_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && mode == 3'd3 && $past(mode) == 3'd3) |-> !fs_out);

  p_toggle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && mode == 3'd5 && $past(mode) == 3'd5 && !frame_start)
      |-> $stable(fs_out));
endmodule

bind fsync_gen fsg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .bit_en(bit_en),
  .mode(mode), .fs_out(fs_out), .frame_start(frame_start)
);

// File: tb/fsync_gen_tb.sv
module fsync_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, bit_en = 1'b1, start_evt = 1'b0, word_done = 1'b0;
  logic fs_in = 1'b0, edge_sel = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [3:0] len_lo = 4'd0, len_hi = 4'd0, words = 4'd0;
  logic [7:0] period = 8'd0;
  logic fs_out, fs_oe, frame_start;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsync_gen u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .bit_en(bit_en), .start_evt(start_evt),
    .word_done(word_done), .fs_in(fs_in), .mode(mode), .len_lo(len_lo),
    .len_hi(len_hi), .period(period), .words(words), .edge_sel(edge_sel),
    .fs_out(fs_out), .fs_oe(fs_oe), .frame_start(frame_start)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic disable_blk();
    en = 1'b0;
    start_evt = 1'b0;
    word_done = 1'b0;
    bit_en = 1'b1;
    step();
  endtask

  // Periodic sweep: mode m, period p, length l; start_evt held high (R4: ignored)
  task automatic run_cfg(input int m, input int p, input int l);
    int per;
    int ph;
    bit pa;
    bit tg;
    int exp_out;
    disable_blk();
    mode = 3'(m);
    period = 8'(p);
    len_lo = 4'(l % 16);
    len_hi = 4'(l / 16);
    start_evt = 1'b1;
    en = 1'b1;
    per = 2 * (p + 1);
    for (int n = 0; n < 3 * per; n++) begin
      step();
      ph = n % per;
      pa = (ph <= l);
      tg = ((n / per) % 2) == 0;
      exp_out = (m == 1) ? int'(!pa) : (m == 2) ? int'(pa) : int'(tg);
      chk((m == 5) ? "R6" : "R2", int'(fs_out), exp_out);
      chk("R4", int'(frame_start), int'(ph == 0));
      chk("R3", int'(fs_oe), 1);
    end
    disable_blk();
    chk("R10", int'(fs_oe), 0);
    chk("R10", int'(frame_start), 0);
    if (m == 5) chk("R6", int'(fs_out), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", int'(fs_oe), 0);
    chk("R10", int'(frame_start), 0);
    chk("R1", int'(fs_out), 0);
    rst_n = 1'b1;
    step();

    for (int m = 1; m <= 5; m++) begin
      if (m == 3 || m == 4) continue;
      for (int p = 1; p <= 3; p++)
        for (int l = 0; l <= 7; l++)
          run_cfg(m, p, l);
    end
    run_cfg(2, 15, 18);   // R2 length built from both halves
    run_cfg(1, 1, 40);    // R9 retrigger at expiry keeps pulse continuous

    // R1: codes 6 and 7 behave as input
    for (int c = 6; c <= 7; c++) begin
      disable_blk();
      mode = 3'(c);
      period = 8'd1;
      en = 1'b1;
      for (int n = 0; n < 6; n++) begin
        step();
        chk("R1", int'(fs_oe), 0);
        chk("R1", int'(fs_out), 0);
      end
    end

    // R7: input mode edge detection
    for (int es = 0; es <= 1; es++) begin
      disable_blk();
      mode = 3'd0;
      period = 8'd0;
      edge_sel = 1'(es);
      fs_in = 1'(es);
      en = 1'b1;
      step();
      step();
      chk("R7", int'(frame_start), 0);
      fs_in = ~fs_in;  // selected edge
      step();
      chk("R7", int'(frame_start), 1);
      step();
      chk("R7", int'(frame_start), 0);
      fs_in = ~fs_in;  // opposite edge
      step();
      chk("R7", int'(frame_start), 0);
      chk("R1", int'(fs_oe), 0);
    end
    fs_in = 1'b0;
    edge_sel = 1'b0;

    // R4 and R5: level low, three words per frame
    disable_blk();
    mode = 3'd3;
    period = 8'd0;
    words = 4'd2;
    en = 1'b1;
    step();
    chk("R5", int'(fs_out), 1);
    start_evt = 1'b1;
    step();
    start_evt = 1'b0;
    chk("R4", int'(frame_start), 1);
    chk("R5", int'(fs_out), 0);
    for (int w = 0; w < 3; w++) begin
      step();
      step();
      word_done = 1'b1;
      step();
      word_done = 1'b0;
      chk("R5", int'(fs_out), (w == 2) ? 1 : 0);
    end

    // R9: start on the same tick as the closing word, level high, one word
    disable_blk();
    mode = 3'd4;
    words = 4'd0;
    en = 1'b1;
    start_evt = 1'b1;
    step();
    start_evt = 1'b0;
    chk("R5", int'(fs_out), 1);
    step();
    word_done = 1'b1;
    start_evt = 1'b1;
    step();
    word_done = 1'b0;
    start_evt = 1'b0;
    chk("R9", int'(fs_out), 1);
    chk("R9", int'(frame_start), 1);
    step();
    word_done = 1'b1;
    step();
    word_done = 1'b0;
    chk("R9", int'(fs_out), 0);

    // R8: frozen while bit_en low, pulse of 4 ticks
    disable_blk();
    mode = 3'd2;
    len_lo = 4'd3;
    len_hi = 4'd0;
    en = 1'b1;
    start_evt = 1'b1;
    step();
    start_evt = 1'b0;
    chk("R8", int'(fs_out), 1);
    bit_en = 1'b0;
    word_done = 1'b1;
    for (int k = 0; k < 5; k++) begin
      step();
      chk("R8", int'(fs_out), 1);
      chk("R8", int'(frame_start), 0);
    end
    word_done = 1'b0;
    bit_en = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      step();
      chk("R8", int'(fs_out), (k <= 3) ? 1 : 0);
    end

    disable_blk();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule